// File: doc/BRIEF.md
# Configurable-Length SPI Transceiver

This block is a full-duplex serial peripheral interface endpoint that can act either as the bus master or as a selected slave. In both roles it moves one bit out and one bit in on every serial clock period. The word length is programmable between 2 and 16 bits. The shift direction (most significant bit first, or least significant bit first) is also programmable, and so are the clock idle level and the sampling edge. In master mode the block generates the serial clock from the module clock with a power-of-two divider and frames every word with an active-low select.

The parallel side is stream-shaped. A single-word transmit holding register accepts a word on `tx_valid && tx_ready`. `tx_ready` stays low until that word has been moved into the shifter, so a producer that sees `tx_ready` low must hold `tx_valid` and `tx_data`. A single-word receive holding register presents each completed word with `rx_valid`. That word stays put until `rx_valid && rx_ready`. If a new word completes while the consumer is still applying back-pressure, the new word is dropped and `rx_overrun` is raised.

In slave mode the serial inputs are brought into the module clock domain by a synchronizer. For this reason the incoming serial clock may run at no more than half the module clock. Configuration inputs are expected to be held steady while a word is in flight.

Top module: `spi_xcvr`

## Requirements
- R1: After reset `tx_ready` is 1, `rx_valid` and `rx_overrun` are 0, `ss_n_out` is 1 and `miso_oe` is 0.
- R2: In master mode each word is shifted out on `mosi_out` while `miso_in` is shifted in. The received word appears on `rx_data`.
- R3: `cfg_bits_m1` holds the word length minus one (1..15 gives 2..16 bits), and the code 0 is treated as 2 bits. A master word produces exactly twice as many SCLK edges as it has bits.
- R4: With `cfg_lsb_first`=1, bit 0 of the word travels first. With 0, bit (length-1) travels first. The same order applies to both directions.
- R5: While no master word is in flight, `sclk_out` rests at `cfg_cpol`. With `cfg_cpha`=0, data is sampled on the leading (away-from-idle) edge, changes on the trailing edge, and the first bit is valid as soon as select goes low. With `cfg_cpha`=1, data changes on the leading edge and is sampled on the trailing edge.
- R6: In master mode every SCLK half period lasts 2^`cfg_div` module clocks. The first edge comes 2^`cfg_div` clocks after `ss_n_out` falls, and `ss_n_out` rises 2^`cfg_div` clocks after the last edge. SCLK toggles only while `ss_n_out` is low.
- R7: `tx_ready` is high exactly when the transmit holding register is empty. In master mode, `ss_n_out` falls on the cycle after a word is accepted, and `tx_ready` returns high at the same time. Bits of `tx_data` at and above the word length are never transmitted.
- R8: When the last bit of a word is captured, `rx_valid` rises. The word is right-justified and zero-extended, and `rx_data` is held until `rx_valid && rx_ready`.
- R9: If a word completes while `rx_valid` is 1 and `rx_ready` is 0, `rx_overrun` is set and the older word is kept. The next read clears `rx_overrun`.
- R10: In slave mode a falling `ss_n_in` moves the holding word into the shifter, or all zeros if the holding register is empty. That word is driven on `miso_out` with `miso_oe` high while the block is selected, `mosi_in` is received, and one word is transferred per select.
- R11: In slave mode words are received correctly with SCLK as fast as half the module clock, that is, with each SCLK level held for one module clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | 0 = sample leading edge, 1 = sample trailing edge |
| cfg_lsb_first | input | 1 | 1 = bit 0 first, 0 = top bit first |
| cfg_bits_m1 | input | 4 | Word length minus one (0 acts as 1) |
| cfg_div | input | 3 | Master half period = 2^cfg_div clocks |
| tx_data | input | 16 | Word to transmit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit holding register empty |
| rx_data | output | 16 | Received word, right-justified |
| rx_valid | output | 1 | Received word present |
| rx_ready | input | 1 | Consumer takes the received word |
| rx_overrun | output | 1 | A completed word was dropped |
| sclk_out | output | 1 | Serial clock driven in master mode |
| ss_n_out | output | 1 | Active-low select driven in master mode |
| mosi_out | output | 1 | Master serial data out |
| miso_in | input | 1 | Master serial data in |
| sclk_in | input | 1 | Serial clock received in slave mode |
| ss_n_in | input | 1 | Active-low select received in slave mode |
| mosi_in | input | 1 | Slave serial data in |
| miso_out | output | 1 | Slave serial data out |
| miso_oe | output | 1 | Slave output enable (selected) |

## Verification
The bench sweeps every length code (including 0), all four clock modes and both bit orders. It compares both directions against words it assembles itself. An off-by-one in the length comparison would show up as a wrong edge count or a truncated word, and a reversed slot mapping would mirror the word. An advance on the very first leading edge in phase-1 mode would drop the first bit. The divider is swept across all settings with each half period timed. A wrong shift amount would stretch or shrink the gaps, including the select setup and hold gaps. Overrun is provoked by two words with no read in between. A design that overwrote the held word, or did not clear the flag on the read, would miscompare. Slave mode is exercised with an empty transmit register, where stale data would leak onto MISO. It is also driven at half the module clock, where a lost edge in the synchronizer would corrupt the received word.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;

  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_RUN  = 2'd1,
    MS_TAIL = 2'd2
  } mst_state_e;

  typedef struct packed {
    logic lead;
    logic trail;
  } sclk_evt_t;

endpackage

// File: rtl/spi_xcvr_sync.sv
module spi_xcvr_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [STAGES-1:0][N-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_xcvr_baud.sv
module spi_xcvr_baud #(
  parameter int SEL_W = 3,
  parameter int CW    = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [CW-1:0] cnt;
  logic [CW:0]   lim;

  always_comb begin
    lim  = ((CW+1)'(1) << sel) - (CW+1)'(1);
    tick = run && ({1'b0, cnt} == lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/spi_xcvr_shifter.sv
module spi_xcvr_shifter #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lsb_first,
  input  logic [IW-1:0] len_m1,
  input  logic          load,
  input  logic [W-1:0]  load_word,
  input  logic          sample_ev,
  input  logic          shift_ev,
  input  logic          in_bit,
  output logic          out_bit,
  output logic          word_done,
  output logic [W-1:0]  rx_word
);
  // Wire slot of the k-th serial bit inside the right-justified word.
  function automatic logic [IW-1:0] slot(input logic lsb, input logic [IW-1:0] last,
                                         input logic [IW-1:0] k);
    return lsb ? k : IW'(last - k);
  endfunction

  logic [W-1:0]  tx_w;
  logic [IW-1:0] idx;       // serial position currently presented
  logic [IW-1:0] cnt;       // serial position to be captured next
  logic          pending;   // a capture happened since the last advance
  logic          finished;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_w      <= '0;
      rx_word   <= '0;
      idx       <= '0;
      cnt       <= '0;
      pending   <= 1'b0;
      finished  <= 1'b1;
      word_done <= 1'b0;
    end else if (load) begin
      tx_w      <= load_word;
      rx_word   <= '0;
      idx       <= '0;
      cnt       <= '0;
      pending   <= 1'b0;
      finished  <= 1'b0;
      word_done <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (sample_ev && !finished) begin
        rx_word[slot(lsb_first, len_m1, cnt)] <= in_bit;
        pending <= 1'b1;
        if (cnt == len_m1) begin
          finished  <= 1'b1;
          word_done <= 1'b1;
        end else begin
          cnt <= cnt + IW'(1);
        end
      end else if (shift_ev && pending && !finished) begin
        idx     <= idx + IW'(1);
        pending <= 1'b0;
      end
    end
  end

  assign out_bit = tx_w[slot(lsb_first, len_m1, idx)];
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
  import spi_xcvr_pkg::*;
#(
  parameter int MAX_BITS    = 16,
  parameter int DIV_W       = 3,
  parameter int SYNC_STAGES = 2,
  localparam int IW         = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_master,
  input  logic                cfg_cpol,
  input  logic                cfg_cpha,
  input  logic                cfg_lsb_first,
  input  logic [IW-1:0]       cfg_bits_m1,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic [MAX_BITS-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_valid,
  input  logic                rx_ready,
  output logic                rx_overrun,
  output logic                sclk_out,
  output logic                ss_n_out,
  output logic                mosi_out,
  input  logic                miso_in,
  input  logic                sclk_in,
  input  logic                ss_n_in,
  input  logic                mosi_in,
  output logic                miso_out,
  output logic                miso_oe
);
  localparam int EW = IW + 1;

  // ---------------- configuration decode ----------------
  logic [IW-1:0] len_m1;
  logic [EW-1:0] last_edge;
  assign len_m1    = (cfg_bits_m1 == '0) ? IW'(1) : cfg_bits_m1;
  assign last_edge = {len_m1, 1'b1};

  // ---------------- transmit holding register ----------------
  logic [MAX_BITS-1:0] tx_hold;
  logic                hold_full;
  logic                load;
  logic                tx_fire;
  assign tx_ready = !hold_full;
  assign tx_fire  = tx_valid && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hold   <= '0;
      hold_full <= 1'b0;
    end else if (load && hold_full) begin
      hold_full <= 1'b0;
    end else if (tx_fire) begin
      tx_hold   <= tx_data;
      hold_full <= 1'b1;
    end
  end

  // ---------------- master sequencer ----------------
  mst_state_e    m_st;
  logic          m_ph;
  logic [EW-1:0] m_ec;
  logic          tick;
  logic          m_start;
  sclk_evt_t     m_evt;

  spi_xcvr_baud #(.SEL_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (m_st != MS_IDLE),
    .sel  (cfg_div),
    .tick (tick)
  );

  assign m_start    = (m_st == MS_IDLE) && cfg_master && hold_full;
  assign m_evt.lead  = (m_st == MS_RUN) && tick && !m_ph;
  assign m_evt.trail = (m_st == MS_RUN) && tick && m_ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= MS_IDLE;
      m_ph <= 1'b0;
      m_ec <= '0;
    end else begin
      case (m_st)
        MS_IDLE: begin
          m_ph <= 1'b0;
          m_ec <= '0;
          if (m_start) m_st <= MS_RUN;
        end
        MS_RUN: begin
          if (tick) begin
            m_ph <= !m_ph;
            m_ec <= m_ec + EW'(1);
            if (m_ec == last_edge) m_st <= MS_TAIL;
          end
        end
        MS_TAIL: begin
          if (tick) m_st <= MS_IDLE;
        end
        default: m_st <= MS_IDLE;
      endcase
    end
  end

  assign sclk_out = cfg_cpol ^ m_ph;
  assign ss_n_out = (m_st == MS_IDLE);

  // ---------------- slave front end ----------------
  logic      sclk_s, ss_n_s, mosi_s;
  logic      s_sclk_prev, s_sel_q, s_sel, s_start, s_edge;
  sclk_evt_t s_evt;

  spi_xcvr_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({sclk_in, ss_n_in, mosi_in}),
    .q    ({sclk_s, ss_n_s, mosi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sclk_prev <= 1'b0;
      s_sel_q     <= 1'b0;
    end else begin
      s_sclk_prev <= sclk_s;
      s_sel_q     <= s_sel;
    end
  end

  assign s_sel       = !ss_n_s && !cfg_master;
  assign s_start     = s_sel && !s_sel_q;
  assign s_edge      = s_sel && s_sel_q && (sclk_s != s_sclk_prev);
  assign s_evt.lead  = s_edge && (sclk_s != cfg_cpol);
  assign s_evt.trail = s_edge && (sclk_s == cfg_cpol);

  // ---------------- shared shifter ----------------
  sclk_evt_t           evt;
  logic                sample_ev, shift_ev, sh_out, word_done;
  logic [MAX_BITS-1:0] rx_word;

  assign evt       = cfg_master ? m_evt : s_evt;
  assign sample_ev = cfg_cpha ? evt.trail : evt.lead;
  assign shift_ev  = cfg_cpha ? evt.lead  : evt.trail;
  assign load      = m_start || s_start;

  spi_xcvr_shifter #(.W(MAX_BITS), .IW(IW)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .lsb_first(cfg_lsb_first),
    .len_m1   (len_m1),
    .load     (load),
    .load_word(hold_full ? tx_hold : '0),
    .sample_ev(sample_ev),
    .shift_ev (shift_ev),
    .in_bit   (cfg_master ? miso_in : mosi_s),
    .out_bit  (sh_out),
    .word_done(word_done),
    .rx_word  (rx_word)
  );

  assign mosi_out = cfg_master && sh_out;
  assign miso_out = !cfg_master && sh_out;
  assign miso_oe  = s_sel_q && s_sel;

  // ---------------- receive holding register ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      rx_overrun <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) rx_overrun <= 1'b0;
      if (word_done) begin
        if (rx_valid && !rx_ready) begin
          rx_overrun <= 1'b1;
        end else begin
          rx_data  <= rx_word;
          rx_valid <= 1'b1;
        end
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_cpol,
  input logic         tx_valid,
  input logic         tx_ready,
  input logic [W-1:0] rx_data,
  input logic         rx_valid,
  input logic         rx_ready,
  input logic         rx_overrun,
  input logic         sclk_out,
  input logic         ss_n_out
);
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n_out |-> sclk_out == cfg_cpol); // R5
  AST_SCLK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_out != $past(sclk_out)) && (cfg_cpol == $past(cfg_cpol)) |-> !ss_n_out); // R6
  AST_TX_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready); // R7
  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data)); // R8
  AST_OVR_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> rx_valid); // R9
  AST_OVR_CLEARS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready |=> !rx_overrun); // R9
endmodule

bind spi_xcvr spi_xcvr_chk #(.W(MAX_BITS)) u_spi_xcvr_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_cpol  (cfg_cpol),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .rx_data   (rx_data),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .rx_overrun(rx_overrun),
  .sclk_out  (sclk_out),
  .ss_n_out  (ss_n_out)
);

// File: tb/test_spi_xcvr.sv
`timescale 1ns/1ps
module test_spi_xcvr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_master = 1'b1, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
  logic [3:0]  cfg_bits_m1 = 4'd7;
  logic [2:0]  cfg_div = 3'd0;
  logic [15:0] tx_data = '0;
  logic        tx_valid = 1'b0, rx_ready = 1'b0;
  logic        miso_in = 1'b0, sclk_in = 1'b0, ss_n_in = 1'b1, mosi_in = 1'b0;
  logic        tx_ready, rx_valid, rx_overrun, sclk_out, ss_n_out, mosi_out, miso_out, miso_oe;
  logic [15:0] rx_data;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  spi_xcvr i_spi_xcvr (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first), .cfg_bits_m1(cfg_bits_m1),
    .cfg_div(cfg_div), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_overrun(rx_overrun),
    .sclk_out(sclk_out), .ss_n_out(ss_n_out), .mosi_out(mosi_out), .miso_in(miso_in),
    .sclk_in(sclk_in), .ss_n_in(ss_n_in), .mosi_in(mosi_in), .miso_out(miso_out),
    .miso_oe(miso_oe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic bitof(input logic [15:0] v, input int k, input int len, input logic lsb);
    if (k >= len) return 1'b0;
    return lsb ? v[k] : v[len-1-k];
  endfunction

  function automatic int lenof(input int code);
    return (code == 0) ? 2 : code + 1;
  endfunction

  task automatic read_rx();
    @(negedge clk) rx_ready = 1'b1;
    @(negedge clk) rx_ready = 1'b0;
  endtask

  // One master word; the bench plays the remote slave.
  task automatic master_xfer(input int code, input logic [15:0] w, input logic [15:0] v,
                             input int dsel, input bit do_read, input logic [15:0] exp_rx);
    int len = lenof(code);
    int mask = (1 << len) - 1;
    int gap = 0, edges = 0, k = 0, bad_gap = 0;
    logic [15:0] got = '0;
    logic prev;
    bit lead, done = 1'b0;
    int guard = 0;
    cfg_master = 1'b1; cfg_bits_m1 = 4'(code); cfg_div = 3'(dsel);
    @(negedge clk);
    check(sclk_out == cfg_cpol && ss_n_out, "R5", "idle SCLK level", int'(sclk_out), int'(cfg_cpol));
    tx_data = w; tx_valid = 1'b1; miso_in = bitof(v, 0, len, cfg_lsb_first);
    @(negedge clk);
    tx_valid = 1'b0;
    check(!tx_ready && ss_n_out, "R7", "holding full after accept", int'(tx_ready), 0);
    @(negedge clk);
    check(!ss_n_out && tx_ready, "R7", "select falls next cycle", int'(ss_n_out), 0);
    prev = sclk_out;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
      gap++;
      if (sclk_out !== prev) begin
        edges++;
        if (gap != (1 << dsel)) bad_gap++;
        gap = 0;
        lead = (sclk_out != cfg_cpol);
        if (lead == !cfg_cpha) begin
          if (cfg_lsb_first) got[k] = mosi_out; else got[len-1-k] = mosi_out;
          k++;
        end
        prev = sclk_out;
      end
      miso_in = bitof(v, k, len, cfg_lsb_first);
      if (ss_n_out) done = 1'b1;
    end
    check(edges == 2 * len, "R3", "SCLK edge count", edges, 2 * len);
    check(bad_gap == 0 && gap == (1 << dsel), "R6", "half period / hold gap", gap, 1 << dsel);
    check(int'(got) == (int'(w) & mask), "R2", "MOSI word (R4 order)", int'(got), int'(w) & mask);
    repeat (3) @(negedge clk);
    check(rx_valid && rx_data == exp_rx, "R8", "received word", int'(rx_data), int'(exp_rx));
    if (do_read) begin
      read_rx();
      check(!rx_valid, "R8", "rx_valid after read", int'(rx_valid), 0);
    end
  endtask

  // One slave word; the bench plays the master with half period h.
  task automatic slave_xfer(input int code, input logic [15:0] w, input logic [15:0] v,
                            input int h, input bit chk_miso, input bit preload, input string req);
    int len = lenof(code);
    int mask = (1 << len) - 1;
    int k = 0;
    int exp_tx = preload ? (int'(w) & mask) : 0;
    logic [15:0] got = '0;
    bit lead, is_sample;
    cfg_master = 1'b0; cfg_bits_m1 = 4'(code);
    @(negedge clk) sclk_in = cfg_cpol;
    if (preload) begin
      tx_data = w; tx_valid = 1'b1;
      @(negedge clk) tx_valid = 1'b0;
    end
    repeat (4) @(negedge clk);
    ss_n_in = 1'b0; mosi_in = bitof(v, 0, len, cfg_lsb_first);
    repeat (8) @(negedge clk);
    check(miso_oe == 1'b1, "R10", "miso_oe while selected", int'(miso_oe), 1);
    for (int e = 0; e < 2 * len; e++) begin
      lead = (e % 2 == 0);
      is_sample = (lead == !cfg_cpha);
      if (is_sample) begin
        if (cfg_lsb_first) got[k] = miso_out; else got[len-1-k] = miso_out;
        k++;
      end
      sclk_in = ~sclk_in;
      if (!is_sample) mosi_in = bitof(v, k, len, cfg_lsb_first);
      repeat (h) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    ss_n_in = 1'b1;
    repeat (4) @(negedge clk);
    check(rx_valid && int'(rx_data) == (int'(v) & mask), req, "slave received word",
          int'(rx_data), int'(v) & mask);
    if (chk_miso)
      check(int'(got) == exp_tx, "R10", "MISO word", int'(got), exp_tx);
    read_rx();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] w, v, v1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(tx_ready && !rx_valid && !rx_overrun && ss_n_out && !miso_oe, "R1", "reset state",
          {tx_ready, rx_valid, rx_overrun, ss_n_out, miso_oe}, 5'b10010);
    check(sclk_out == 1'b0, "R1", "idle SCLK cpol=0", int'(sclk_out), 0);
    cfg_cpol = 1'b1;
    @(negedge clk);
    check(sclk_out == 1'b1, "R5", "idle SCLK cpol=1", int'(sclk_out), 1);

    // Master sweep: modes, orders, all length codes (R2 R3 R4 R5 R7 R8)
    for (int m = 0; m < 4; m++)
      for (int o = 0; o < 2; o++)
        for (int c = 0; c < 16; c++) begin
          cfg_cpol = m[1]; cfg_cpha = m[0]; cfg_lsb_first = o[0];
          w = 16'((c * 16'h3b5) ^ (m * 16'h1111) ^ (o * 16'h8421) ^ 16'ha5c3);
          v = 16'(w * 3 + 16'h5a1 + c);
          master_xfer(c, w, v, 0, 1'b1, 16'(int'(v) & ((1 << lenof(c)) - 1)));
        end

    // Divider sweep (R6)
    for (int d = 0; d < 8; d++) begin
      cfg_cpol = d[0]; cfg_cpha = d[1]; cfg_lsb_first = d[2];
      w = 16'(16'h1234 + d * 16'h0f0f);
      v = 16'(16'hc3a5 ^ (d * 16'h0123));
      master_xfer(3, w, v, d, 1'b1, 16'(int'(v) & 16'hf));
    end

    // Overrun (R9)
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_lsb_first = 1'b0;
    v1 = 16'h00b6;
    master_xfer(7, 16'h5a5a, v1, 1, 1'b0, v1);
    check(!rx_overrun, "R9", "no overrun after first word", int'(rx_overrun), 0);
    master_xfer(7, 16'h3c3c, 16'h0049, 1, 1'b0, v1);
    check(rx_overrun == 1'b1, "R9", "overrun flag set", int'(rx_overrun), 1);
    check(rx_data == v1, "R9", "older word kept", int'(rx_data), int'(v1));
    read_rx();
    check(!rx_overrun && !rx_valid, "R9", "flag cleared by read",
          {rx_overrun, rx_valid}, 0);

    // Slave sweep (R10 R4 R5)
    for (int m = 0; m < 4; m++)
      for (int o = 0; o < 2; o++)
        for (int i = 0; i < 5; i++) begin
          int c = (i == 0) ? 1 : (i == 1) ? 4 : (i == 2) ? 7 : (i == 3) ? 11 : 15;
          cfg_cpol = m[1]; cfg_cpha = m[0]; cfg_lsb_first = o[0];
          w = 16'((c * 16'h2f1) ^ (m * 16'h0707) ^ (o * 16'hf00f) ^ 16'h96e1);
          v = 16'(w * 5 + 16'h1d3 + m);
          slave_xfer(c, w, v, 8, 1'b1, 1'b1, "R10");
        end

    // Slave with empty holding register sends zeros (R10)
    cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_lsb_first = 1'b0;
    slave_xfer(9, 16'hffff, 16'h02a7, 8, 1'b1, 1'b0, "R10");

    // Slave SCLK at half the module clock (R11)
    for (int m = 0; m < 4; m++) begin
      cfg_cpol = m[1]; cfg_cpha = m[0]; cfg_lsb_first = m[0] ^ m[1];
      slave_xfer(15, 16'h0000, 16'(16'hb7e4 ^ (m * 16'h1248)), 1, 1'b0, 1'b0, "R11");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule